// File: doc/BRIEF.md
# Instruction Bundle Issue-Group Splitter

This block takes 128-bit instruction bundles over a valid/ready handshake and emits their three instruction slots one per transfer, always in slot order. Each emitted instruction carries a flag that says whether it closes its parallel issue group. The flag is derived from a two-bit template carried in the bundle. The template either names the slot that ends the current group or states that the group carries on into the following bundle.

Group state is tracked across bundle boundaries. A bundle can be flagged as a branch entry point. If such a bundle arrives while a group is still open, the block reports an error, because a branch must land on a group boundary. A new bundle is accepted only when the output stage is free. The one exception is the cycle in which the last slot of the previous bundle is handed off. With the sink always ready, this gives one instruction per cycle.

Top module: `bundle_group_splitter`

## Requirements
- R1: Bundle layout: the template is bits [1:0], slot A is bits [43:2], slot B is bits [85:44] and slot C is bits [127:86]. Slots leave in the order A, B, C with `out_slot` equal to 0, 1 and 2. Slot A is offered in the cycle after the bundle is accepted.
- R2: Template 0 sets the end-of-group flag on slot A and on slot C, but not on slot B.
- R3: Template 1 sets the end-of-group flag on slots B and C, but not on slot A.
- R4: Template 2 sets the end-of-group flag on slot C only.
- R5: Template 3 sets the end-of-group flag on none of the three slots. `grp_open` is 1 from the edge at which that bundle is accepted.
- R6: Once set, `grp_open` stays 1 until an instruction with the end-of-group flag is handed off. It is 0 after that transfer edge.
- R7: `in_ready` is 1 when no slot is pending, or when slot C is offered while `out_ready` is 1. It is 0 in every other case. With `out_ready` held at 1, back-to-back bundles are accepted exactly 3 cycles apart.
- R8: While `out_valid` is 1 and `out_ready` is 0, the values of `out_insn`, `out_slot` and `out_eog` hold unchanged to the next cycle.
- R9: `out_err` is 1 for exactly the one cycle after a bundle with `in_branch_tgt` = 1 is accepted while a group is open. A group closed by a handoff in that same cycle counts as closed. In every other case `out_err` is 0.
- R10: A synchronous active-high `rst` clears `out_valid`, `grp_open` and `out_err` at the next edge, and `in_ready` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Bundle can be taken this cycle |
| in_bundle | input | 128 | Bundle: template plus three slots |
| in_branch_tgt | input | 1 | The offered bundle is entered by a branch |
| out_valid | output | 1 | Instruction offered |
| out_ready | input | 1 | Sink takes the offered instruction |
| out_insn | output | 42 | Instruction slot contents |
| out_slot | output | 2 | Slot index within the bundle (0=A, 1=B, 2=C) |
| out_eog | output | 1 | The offered instruction closes its issue group |
| out_err | output | 1 | One-cycle pulse: branch entry into an open group |
| grp_open | output | 1 | A group is carried over from an earlier bundle |

## Verification
There is one register stage between a handshake and each result. Slot A shows up one edge after acceptance, and each later slot shows up one edge after the previous slot is handed off. `out_err` and the update of `grp_open` are also due one edge after the acceptance or handoff that causes them. The bench drives inputs just after a rising edge and samples on the falling edge. At that point it compares each handed-off instruction against the next item in a queue filled when the bundle was sent. It counts clock edges between acceptances to confirm the three-cycle spacing, and it checks the error pulse on the falling edge that directly follows acceptance.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

  localparam int DEF_SLOT_W = 42;
  localparam int DEF_NSLOT  = 3;

  // A template code at or above the slot count means the group runs on.
  function automatic bit code_carries(input int code, input int nslot);
    return code >= nslot;
  endfunction

  // Does a given slot close its group under a given template code?
  function automatic bit slot_closes(input int code, input int slot, input int nslot);
    if (code_carries(code, nslot)) return 1'b0;
    return (slot == code) || (slot == nslot - 1);
  endfunction

endpackage

// File: rtl/bgs_field_split.sv
module bgs_field_split
  import bgs_pkg::*;
#(
  parameter int SLOT_W = DEF_SLOT_W,
  parameter int NSLOT  = DEF_NSLOT,
  localparam int TMPL_W   = $clog2(NSLOT + 1),
  localparam int BUNDLE_W = NSLOT * SLOT_W + TMPL_W
) (
  input  logic [BUNDLE_W-1:0]          bundle,
  output logic [NSLOT-1:0][SLOT_W-1:0] slots,
  output logic [TMPL_W-1:0]            tmpl,
  output logic [NSLOT-1:0]             eog_mask,
  output logic                         carry
);

  assign tmpl  = bundle[TMPL_W-1:0];
  assign carry = code_carries(int'(tmpl), NSLOT);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign slots[i]    = bundle[TMPL_W + i*SLOT_W +: SLOT_W];
    assign eog_mask[i] = slot_closes(int'(tmpl), i, NSLOT);
  end

endmodule

// File: rtl/bgs_slot_seq.sv
module bgs_slot_seq #(
  parameter int SLOT_W = 42,
  parameter int NSLOT  = 3,
  localparam int IDX_W = $clog2(NSLOT)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [NSLOT-1:0][SLOT_W-1:0] load_slots,
  input  logic [NSLOT-1:0]             load_eog,
  input  logic                         out_ready,
  output logic                         in_ready,
  output logic                         out_valid,
  output logic [SLOT_W-1:0]            out_insn,
  output logic [IDX_W-1:0]             out_slot,
  output logic                         out_eog,
  output logic                         accept,
  output logic                         emit
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NSLOT - 1);

  logic                         busy_q;
  logic [IDX_W-1:0]             idx_q;
  logic [NSLOT-1:0][SLOT_W-1:0] slot_q;
  logic [NSLOT-1:0]             eog_q;
  logic                         last_emit;

  function automatic logic at_last(input logic [IDX_W-1:0] i);
    return i == LAST;
  endfunction

  assign emit      = busy_q && out_ready;
  assign last_emit = emit && at_last(idx_q);
  assign in_ready  = !busy_q || last_emit;
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (emit) begin
      if (at_last(idx_q)) busy_q <= 1'b0;
      else                idx_q  <= idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      slot_q <= load_slots;
      eog_q  <= load_eog;
    end
  end

  assign out_valid = busy_q;
  assign out_insn  = slot_q[idx_q];
  assign out_eog   = eog_q[idx_q];
  assign out_slot  = idx_q;

endmodule

// File: rtl/bgs_group_track.sv
module bgs_group_track (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic carry,
  input  logic branch_tgt,
  input  logic emit,
  input  logic emit_eog,
  output logic grp_open,
  output logic open_eff,
  output logic err
);

  logic open_q;
  logic err_q;
  logic closing;

  assign closing  = emit && emit_eog;
  // A group closed by a handoff in this very cycle no longer counts as open.
  assign open_eff = open_q && !closing;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= accept && branch_tgt && open_eff;
      if (accept && carry) open_q <= 1'b1;
      else if (closing)    open_q <= 1'b0;
    end
  end

  assign grp_open = open_q;
  assign err      = err_q;

endmodule

// File: rtl/bundle_group_splitter.sv
module bundle_group_splitter
  import bgs_pkg::*;
#(
  parameter int SLOT_W = DEF_SLOT_W,
  parameter int NSLOT  = DEF_NSLOT,
  localparam int TMPL_W   = $clog2(NSLOT + 1),
  localparam int IDX_W    = $clog2(NSLOT),
  localparam int BUNDLE_W = NSLOT * SLOT_W + TMPL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [BUNDLE_W-1:0] in_bundle,
  input  logic                in_branch_tgt,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SLOT_W-1:0]   out_insn,
  output logic [IDX_W-1:0]    out_slot,
  output logic                out_eog,
  output logic                out_err,
  output logic                grp_open
);

  logic [NSLOT-1:0][SLOT_W-1:0] slots_w;
  logic [TMPL_W-1:0]            tmpl_w;
  logic [NSLOT-1:0]             eog_mask_w;
  logic                         carry_w;
  logic                         accept_w;
  logic                         emit_w;
  logic                         open_eff_w;

  bgs_field_split #(.SLOT_W(SLOT_W), .NSLOT(NSLOT)) u_split (
    .bundle   (in_bundle),
    .slots    (slots_w),
    .tmpl     (tmpl_w),
    .eog_mask (eog_mask_w),
    .carry    (carry_w)
  );

  bgs_slot_seq #(.SLOT_W(SLOT_W), .NSLOT(NSLOT)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .load_slots (slots_w),
    .load_eog   (eog_mask_w),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_insn   (out_insn),
    .out_slot   (out_slot),
    .out_eog    (out_eog),
    .accept     (accept_w),
    .emit       (emit_w)
  );

  bgs_group_track u_grp (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept_w),
    .carry      (carry_w),
    .branch_tgt (in_branch_tgt),
    .emit       (emit_w),
    .emit_eog   (out_eog),
    .grp_open   (grp_open),
    .open_eff   (open_eff_w),
    .err        (out_err)
  );

endmodule

// File: rtl/bgs_checker.sv
module bgs_checker #(
  parameter int SLOT_W = 42,
  parameter int NSLOT  = 3,
  localparam int TMPL_W = $clog2(NSLOT + 1),
  localparam int IDX_W  = $clog2(NSLOT)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic [TMPL_W-1:0] in_tmpl,
  input logic              in_branch_tgt,
  input logic              out_valid,
  input logic              out_ready,
  input logic [SLOT_W-1:0] out_insn,
  input logic [IDX_W-1:0]  out_slot,
  input logic              out_eog,
  input logic              out_err,
  input logic              grp_open,
  input logic              accept,
  input logic              emit,
  input logic              open_eff
);

  localparam logic [IDX_W-1:0]  LAST  = IDX_W'(NSLOT - 1);
  localparam logic [TMPL_W-1:0] CARRY = TMPL_W'(NSLOT);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && !grp_open && !out_err)); // R10

  AST_LOAD_STARTS_AT_A: assert property (@(posedge clk) disable iff (rst)
    accept |=> (out_valid && out_slot == '0)); // R1

  AST_SLOT_STEPS: assert property (@(posedge clk) disable iff (rst)
    (emit && out_slot != LAST) |=> (out_valid && out_slot == IDX_W'($past(out_slot) + 1'b1))); // R1

  AST_CARRY_OPENS: assert property (@(posedge clk) disable iff (rst)
    (accept && in_tmpl == CARRY) |=> (grp_open && !out_eog)); // R5

  AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (grp_open && !(emit && out_eog)) |=> grp_open); // R6

  AST_NO_EARLY_TAKE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !(out_ready && out_slot == LAST)) |-> !in_ready); // R7

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_insn) && $stable(out_slot) && $stable(out_eog))); // R8

  AST_ERR_RAISED: assert property (@(posedge clk) disable iff (rst)
    (accept && in_branch_tgt && open_eff) |=> out_err); // R9

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(accept && in_branch_tgt) |=> !out_err); // R9

endmodule

bind bundle_group_splitter bgs_checker #(.SLOT_W(SLOT_W), .NSLOT(NSLOT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_ready      (in_ready),
  .in_tmpl       (tmpl_w),
  .in_branch_tgt (in_branch_tgt),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_insn      (out_insn),
  .out_slot      (out_slot),
  .out_eog       (out_eog),
  .out_err       (out_err),
  .grp_open      (grp_open),
  .accept        (accept_w),
  .emit          (emit_w),
  .open_eff      (open_eff_w)
);

// File: tb/sim_bundle_group_splitter.sv
`timescale 1ns/1ps
module sim_bundle_group_splitter;
  localparam int SW = 42;
  localparam int BW = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [BW-1:0] in_bundle = '0;
  logic          in_tgt = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [SW-1:0] out_insn;
  logic [1:0]    out_slot;
  logic          out_eog;
  logic          out_err;
  logic          grp_open;

  always #4 clk = ~clk;

  bundle_group_splitter #(.SLOT_W(SW), .NSLOT(3)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bundle(in_bundle), .in_branch_tgt(in_tgt), .out_valid(out_valid),
    .out_ready(out_ready), .out_insn(out_insn), .out_slot(out_slot),
    .out_eog(out_eog), .out_err(out_err), .grp_open(grp_open)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int ready_mode = 0;   // 0 always ready, 1 patterned stalls, 2 manual
  int acc_cyc = 0;
  logic prev_carry = 1'b0;
  // item: {template, insn, slot, eog}
  logic [46:0] sb_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [SW-1:0] slotval(input int tag, input int s);
    return {8'(tag), 2'(s), 32'h5A5A0000 ^ 32'(tag * 16 + s)};
  endfunction

  function automatic bit exp_eog(input logic [1:0] t, input int s);
    case (t)
      2'd0:    return (s == 0) || (s == 2);
      2'd1:    return s >= 1;
      2'd2:    return s == 2;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string eog_req(input logic [1:0] t);
    case (t)
      2'd0:    return "R2";
      2'd1:    return "R3";
      2'd2:    return "R4";
      default: return "R5";
    endcase
  endfunction

  // Ready pattern driver
  initial begin
    forever begin
      @(posedge clk); #1;
      if (ready_mode == 0)      out_ready = 1'b1;
      else if (ready_mode == 1) out_ready = ((cyc * 7) % 5) < 3;
    end
  end

  // Monitor / scoreboard
  bit         stall_seen = 1'b0;
  logic [SW-1:0] stall_insn;
  logic [1:0] stall_slot;
  logic       stall_eog;
  always @(negedge clk) begin
    if (rst) begin
      stall_seen = 1'b0;
    end else begin
      if (stall_seen) begin
        check(out_valid && out_insn == stall_insn && out_slot == stall_slot && out_eog == stall_eog,
              "R8", "held output", {out_valid, out_slot, out_insn}, {1'b1, stall_slot, stall_insn});
      end
      stall_seen = out_valid && !out_ready;
      stall_insn = out_insn;
      stall_slot = out_slot;
      stall_eog  = out_eog;
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R1", "unexpected instruction", {out_slot, out_insn}, 0);
        end else begin
          logic [46:0] it;
          it = sb_q.pop_front();
          check(out_insn == it[44:3], "R1", "slot contents", out_insn, it[44:3]);
          check(out_slot == it[2:1], "R1", "slot index", out_slot, it[2:1]);
          check(out_eog == it[0], eog_req(it[46:45]), "end-of-group flag", out_eog, it[0]);
        end
      end
    end
  end

  task automatic send(input logic [1:0] t, input logic tgt, input int tag);
    logic rdy;
    logic e_err;
    for (int s = 0; s < 3; s++)
      sb_q.push_back({t, slotval(tag, s), 2'(s), exp_eog(t, s)});
    e_err = tgt && prev_carry;
    prev_carry = (t == 2'd3);
    in_bundle = {slotval(tag, 2), slotval(tag, 1), slotval(tag, 0), t};
    in_tgt = tgt;
    in_valid = 1'b1;
    rdy = 1'b0;
    while (!rdy) begin
      @(negedge clk);
      rdy = in_ready;
      @(posedge clk);
    end
    #1;
    acc_cyc = cyc;
    in_valid = 1'b0;
    in_tgt = 1'b0;
    @(negedge clk);
    check(out_err == e_err, "R9", "error pulse after acceptance", out_err, e_err);
    @(posedge clk); #1;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (out_valid || sb_q.size() != 0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", cyc, 0);
    finish_run();
  end

  initial begin
    int a0;
    // Reset state (R10)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R10", "out_valid in reset", out_valid, 0);
    check(!grp_open, "R10", "grp_open in reset", grp_open, 0);
    check(!out_err, "R10", "out_err in reset", out_err, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(in_ready, "R10", "in_ready after reset", in_ready, 1);
    @(posedge clk); #1;

    // Each closing template (R2 R3 R4)
    send(2'd0, 1'b0, 1);
    send(2'd1, 1'b0, 2);
    send(2'd2, 1'b0, 3);
    wait_idle();
    @(negedge clk);
    check(!grp_open, "R6", "no group open after closing templates", grp_open, 0);
    @(posedge clk); #1;

    // Back-to-back spacing (R7)
    send(2'd2, 1'b0, 4);
    a0 = acc_cyc;
    send(2'd0, 1'b0, 5);
    check(acc_cyc - a0 == 3, "R7", "acceptance spacing", acc_cyc - a0, 3);
    a0 = acc_cyc;
    send(2'd1, 1'b0, 6);
    check(acc_cyc - a0 == 3, "R7", "acceptance spacing", acc_cyc - a0, 3);
    wait_idle();

    // Carry-over template and sticky open state (R5 R6)
    send(2'd3, 1'b0, 20);
    wait_idle();
    @(negedge clk);
    check(grp_open, "R5", "group open after carry template", grp_open, 1);
    @(posedge clk); #1;
    ready_mode = 2;
    out_ready = 1'b0;
    send(2'd1, 1'b0, 21);
    @(negedge clk);
    check(grp_open, "R6", "open while slot A stalled", grp_open, 1);
    check(!in_ready, "R7", "in_ready with slot pending", in_ready, 0);
    @(posedge clk); #1 out_ready = 1'b1;
    @(negedge clk);
    check(!in_ready, "R7", "in_ready while slot A offered", in_ready, 0);
    @(posedge clk); #1 out_ready = 1'b0;
    @(negedge clk);
    check(grp_open, "R6", "open after non-closing slot A", grp_open, 1);
    @(posedge clk); #1 out_ready = 1'b1;
    @(posedge clk); #1 out_ready = 1'b0;
    @(negedge clk);
    check(!grp_open, "R6", "closed after slot B handoff", grp_open, 0);
    check(out_slot == 2'd2, "R1", "slot C pending", out_slot, 2);
    @(posedge clk); #1 out_ready = 1'b1;
    @(negedge clk);
    check(in_ready, "R7", "in_ready while slot C taken", in_ready, 1);
    ready_mode = 0;
    wait_idle();

    // Branch entry checks (R9)
    send(2'd3, 1'b0, 30);
    send(2'd0, 1'b1, 31);
    send(2'd2, 1'b1, 32);
    send(2'd3, 1'b0, 33);
    send(2'd2, 1'b0, 34);
    send(2'd1, 1'b1, 35);
    send(2'd3, 1'b0, 36);
    send(2'd3, 1'b1, 37);
    send(2'd0, 1'b0, 38);
    wait_idle();

    // Patterned back-pressure
    ready_mode = 1;
    for (int k = 0; k < 12; k++)
      send(2'((k * 5 + 1) % 4), (k % 3) == 0, 40 + k);
    wait_idle();
    ready_mode = 0;
    @(negedge clk);
    check(grp_open == prev_carry, "R6", "open state after stalled run", grp_open, prev_carry);
    @(posedge clk); #1;

    // Reset in mid-bundle (R10)
    ready_mode = 2;
    out_ready = 1'b0;
    send(2'd3, 1'b0, 60);
    @(negedge clk);
    check(grp_open, "R5", "open right after carry acceptance", grp_open, 1);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    sb_q.delete();
    prev_carry = 1'b0;
    @(negedge clk);
    check(!out_valid, "R10", "out_valid after mid reset", out_valid, 0);
    check(!grp_open, "R10", "grp_open after mid reset", grp_open, 0);
    check(!out_err, "R10", "out_err after mid reset", out_err, 0);
    check(in_ready, "R10", "in_ready after mid reset", in_ready, 1);
    @(posedge clk); #1;
    ready_mode = 0;
    send(2'd0, 1'b1, 61);
    wait_idle();
    check(sb_q.size() == 0, "R1", "scoreboard drained", sb_q.size(), 0);

    finish_run();
  end

endmodule